// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Front End

This block is the slave side of an 8-bit parallel bus through which a host microcontroller reaches a core's command, data and status space. A strap input chooses between two handshake styles. In the first, separate active-low read and write strobes mark each access. In the second, an active-high enable pulse carries a read/write direction level. A register-select line splits every access into a data cycle or a command/status cycle.

All host inputs are brought into the core clock domain through synchroniser chains. Strobe edges are detected there, and each access is classified as one of four cycle kinds: data write, data read, command write or status read. A command write latches a register address. Later data cycles produce a one-cycle write pulse or read request at that address toward a register file. Read results come from the register file or from a status input, and are driven back while the host holds its read strobe. An active-low wait output tells the host to hold off while the core reports busy, and for a short settling window after every access.

Top module: `mcubus_host_if`

## Requirements
- R1: With `mode_i` low (strobe/strobe mode), chip select low and `rs_i` low, the rising edge of `strb_b_i` (active-low write strobe) produces exactly one `reg_we_o` pulse. During that pulse `reg_wdata_o` holds the bus byte and `reg_addr_o` holds the latched address.
- R2: With `mode_i` high (enable/direction mode), a falling edge of `strb_a_i` (active-high enable) while `strb_b_i` is low (write direction) and `rs_i` is low produces exactly one `reg_we_o` pulse carrying the bus byte.
- R3: A write with `rs_i` high is a command write. It loads the bus byte into `reg_addr_o` and raises no `reg_we_o` or `reg_re_o`.
- R4: A data read produces exactly one `reg_re_o` pulse at the latched address, and `db_o` then returns `reg_rdata_i` as sampled during that pulse. In strobe/strobe mode a data read is `strb_a_i` low with `rs_i` low. In enable/direction mode it is `strb_a_i` high with `strb_b_i` high and `rs_i` low.
- R5: A read with `rs_i` high returns `status_i` on `db_o` and raises no `reg_re_o`.
- R6: While `cs_n_i` is high, strobe activity is ignored: no pulse is produced and `reg_addr_o` keeps its value.
- R7: Every pulse on `reg_we_o` or `reg_re_o` lasts one clock cycle, the two never coincide, and each host access yields exactly one pulse.
- R8: `db_oe_o` is high only while `cs_n_i` is low and a read strobe is active, and it falls as soon as either condition ends.
- R9: `wait_n_o` goes low in the cycle after `core_busy_i` is seen high. It stays low for at least `HOLD_CYC` cycles after each decoded access, and it returns high once neither condition holds.
- R10: After reset `reg_addr_o` is zero, `db_oe_o` is low, `wait_n_o` is high and no pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Handshake strap: 0 strobe/strobe, 1 enable/direction |
| cs_n_i | input | 1 | Active-low chip select |
| rs_i | input | 1 | Register select: 0 data, 1 command/status |
| strb_a_i | input | 1 | Read strobe (active low) or enable (active high) |
| strb_b_i | input | 1 | Write strobe (active low) or direction (1 read, 0 write) |
| db_i | input | DW | Host data bus, inbound |
| db_o | output | DW | Host data bus, outbound read data |
| db_oe_o | output | 1 | Output enable for the host bus driver |
| wait_n_o | output | 1 | Active-low wait toward the host |
| core_busy_i | input | 1 | Core not ready |
| reg_addr_o | output | DW | Latched register address |
| reg_wdata_o | output | DW | Write data for the register file |
| reg_we_o | output | 1 | One-cycle register write pulse |
| reg_re_o | output | 1 | One-cycle register read request |
| reg_rdata_i | input | DW | Register file read data at `reg_addr_o` |
| status_i | input | DW | Status byte returned on status reads |

## Verification
The bench runs every cycle kind in both handshake styles. A decoder that swapped the meaning of the two strobes between modes would raise a pulse on the wrong edge, or none, and the write scoreboard would fall out of step. Strobe toggling with chip select high is checked both at the pulse outputs and through `reg_addr_o`, which would move if a command write leaked through. It also watches for stray `reg_re_o` on status reads and for a second pulse from one access, since an edge detector that fired on both strobe edges would produce one. Output-enable release on strobe end, the wait assertion under a busy core, and the wait assertion right after each access are checked as well. A missing hold window would let the host start its next access before the previous one had settled.

// File: rtl/mcubus_pkg.sv
package mcubus_pkg;

   typedef enum logic [1:0] {
      CYC_DATA_WR = 2'd0,
      CYC_DATA_RD = 2'd1,
      CYC_CMD_WR  = 2'd2,
      CYC_STAT_RD = 2'd3
   } cyc_e;

   // Effective handshake: 0 follows the strap, 1 forces strobe/strobe, 2 forces enable/direction
   function automatic logic eff_mode(input int unsigned sel, input logic strap);
      if (sel == 1) return 1'b0;
      if (sel == 2) return 1'b1;
      return strap;
   endfunction

   function automatic logic rd_level(input logic m, input logic a, input logic b);
      return m ? (a & b) : ~a;
   endfunction

   function automatic logic wr_level(input logic m, input logic a, input logic b);
      return m ? (a & ~b) : ~b;
   endfunction

endpackage

// File: rtl/mcubus_sync.sv
module mcubus_sync #(
   parameter int unsigned       W       = 8,
   parameter int unsigned       STAGES  = 2,
   parameter logic [W-1:0]      RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   initial begin
      assert (STAGES >= 2) else $error("mcubus_sync: STAGES must be at least 2");
      assert (W >= 1)      else $error("mcubus_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg[gi] <= RST_VAL;
            end else if (gi == 0) begin
               stg[gi] <= d_i;
            end else begin
               stg[gi] <= stg[(gi == 0) ? 0 : gi - 1];
            end
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/mcubus_decode.sv
module mcubus_decode
   import mcubus_pkg::*;
#(
   parameter int unsigned BUS_MODE = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_s,
   input  logic cs_n_s,
   input  logic rs_s,
   input  logic a_s,
   input  logic b_s,
   output logic acc_vld_o,
   output cyc_e acc_type_o
);

   initial begin
      assert (BUS_MODE <= 2) else $error("mcubus_decode: BUS_MODE must be 0, 1 or 2");
   end

   logic mode_eff;
   logic sel;
   logic rd_lvl;
   logic wr_lvl;
   logic sel_rd;
   logic sel_wr;
   logic sel_rd_q;
   logic sel_wr_q;
   logic rs_q;
   logic rd_start;
   logic wr_done;

   generate
      if (BUS_MODE == 0) begin : g_strap
         assign mode_eff = mode_s;
      end else begin : g_fixed
         assign mode_eff = eff_mode(BUS_MODE, 1'b0);
      end
   endgenerate

   assign sel    = ~cs_n_s;
   assign rd_lvl = rd_level(mode_eff, a_s, b_s);
   assign wr_lvl = wr_level(mode_eff, a_s, b_s);
   assign sel_rd = sel & rd_lvl;
   assign sel_wr = sel & wr_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_rd_q <= 1'b0;
         sel_wr_q <= 1'b0;
         rs_q     <= 1'b0;
      end else begin
         sel_rd_q <= sel_rd;
         sel_wr_q <= sel_wr;
         rs_q     <= rs_s;
      end
   end

   // read begins on strobe assertion; write completes on strobe release
   assign rd_start = sel_rd & ~sel_rd_q;
   assign wr_done  = sel_wr_q & ~wr_lvl;

   always_comb begin
      acc_vld_o   = 1'b0;
      acc_type_o  = CYC_DATA_WR;
      if (wr_done) begin
         acc_vld_o  = 1'b1;
         acc_type_o = rs_q ? CYC_CMD_WR : CYC_DATA_WR;
      end else if (rd_start) begin
         acc_vld_o  = 1'b1;
         acc_type_o = rs_s ? CYC_STAT_RD : CYC_DATA_RD;
      end
   end

   // R6: deselected host produces no access
   p_idle_no_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_s && $past(cs_n_s)) |-> !acc_vld_o);

   // R7: one access per strobe, never back-to-back from one write
   p_wr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);

endmodule

// File: rtl/mcubus_regport.sv
module mcubus_regport
   import mcubus_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_vld_i,
   input  cyc_e          acc_type_i,
   input  logic [DW-1:0] din_s,
   input  logic [DW-1:0] reg_rdata_i,
   input  logic [DW-1:0] status_i,
   output logic [DW-1:0] reg_addr_o,
   output logic [DW-1:0] reg_wdata_o,
   output logic          reg_we_o,
   output logic          reg_re_o,
   output logic [DW-1:0] rd_hold_o
);

   logic [DW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic          we_q;
   logic          re_q;
   logic [DW-1:0] hold_q;
   logic          cmd_wr;

   assign cmd_wr = acc_vld_i && (acc_type_i == CYC_CMD_WR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         we_q    <= 1'b0;
         re_q    <= 1'b0;
         hold_q  <= '0;
      end else begin
         we_q <= 1'b0;
         re_q <= 1'b0;
         if (acc_vld_i) begin
            unique case (acc_type_i)
               CYC_CMD_WR:  addr_q <= din_s;
               CYC_DATA_WR: begin
                  wdata_q <= din_s;
                  we_q    <= 1'b1;
               end
               CYC_DATA_RD: begin
                  hold_q  <= reg_rdata_i;
                  re_q    <= 1'b1;
               end
               CYC_STAT_RD: hold_q <= status_i;
               default: ;
            endcase
         end
      end
   end

   assign reg_addr_o  = addr_q;
   assign reg_wdata_o = wdata_q;
   assign reg_we_o    = we_q;
   assign reg_re_o    = re_q;
   assign rd_hold_o   = hold_q;

   // R3/R6: address moves only on a command write
   p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wr |=> $stable(addr_q));

   // R7: write and read pulses never coincide and never stretch
   p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({we_q, re_q}));
   p_we_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |=> !we_q);

endmodule

// File: rtl/mcubus_waitgen.sv
module mcubus_waitgen #(
   parameter int unsigned HOLD_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic acc_vld_i,
   input  logic core_busy_i,
   output logic wait_n_o
);

   localparam int unsigned CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC);

   initial begin
      assert (HOLD_CYC >= 1) else $error("mcubus_waitgen: HOLD_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          wait_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         wait_n_q <= 1'b1;
      end else begin
         if (acc_vld_i) begin
            cnt_q <= HOLD_LD;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
         wait_n_q <= ~(core_busy_i | acc_vld_i | (cnt_q != '0));
      end
   end

   assign wait_n_o = wait_n_q;

   // R9: busy core and fresh access both hold the host off
   p_busy_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      core_busy_i |=> !wait_n_q);
   p_access_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld_i |=> (!wait_n_q ##1 !wait_n_q));

endmodule

// File: rtl/mcubus_host_if.sv
module mcubus_host_if
   import mcubus_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYC    = 2,
   parameter int unsigned BUS_MODE    = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_i,
   input  logic          cs_n_i,
   input  logic          rs_i,
   input  logic          strb_a_i,
   input  logic          strb_b_i,
   input  logic [DW-1:0] db_i,
   output logic [DW-1:0] db_o,
   output logic          db_oe_o,
   output logic          wait_n_o,
   input  logic          core_busy_i,
   output logic [DW-1:0] reg_addr_o,
   output logic [DW-1:0] reg_wdata_o,
   output logic          reg_we_o,
   output logic          reg_re_o,
   input  logic [DW-1:0] reg_rdata_i,
   input  logic [DW-1:0] status_i
);

   localparam int unsigned SW = DW + 5;
   localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, {DW{1'b0}}};

   initial begin
      assert (DW >= 1)          else $error("mcubus_host_if: DW must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("mcubus_host_if: SYNC_STAGES must be at least 2");
      assert (BUS_MODE <= 2)    else $error("mcubus_host_if: BUS_MODE must be 0, 1 or 2");
   end

   logic [SW-1:0] raw_vec;
   logic [SW-1:0] syn_vec;
   logic          mode_s;
   logic          cs_n_s;
   logic          rs_s;
   logic          a_s;
   logic          b_s;
   logic [DW-1:0] din_s;
   logic          acc_vld;
   cyc_e          acc_type;
   logic [DW-1:0] rd_hold;
   logic          mode_raw;

   assign raw_vec = {mode_i, cs_n_i, rs_i, strb_a_i, strb_b_i, db_i};

   mcubus_sync #(
      .W       (SW),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_vec),
      .q_o   (syn_vec)
   );

   assign {mode_s, cs_n_s, rs_s, a_s, b_s, din_s} = syn_vec;

   mcubus_decode #(
      .BUS_MODE (BUS_MODE)
   ) u_decode (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_s      (mode_s),
      .cs_n_s      (cs_n_s),
      .rs_s        (rs_s),
      .a_s         (a_s),
      .b_s         (b_s),
      .acc_vld_o   (acc_vld),
      .acc_type_o  (acc_type)
   );

   mcubus_regport #(
      .DW (DW)
   ) u_regport (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_vld_i   (acc_vld),
      .acc_type_i  (acc_type),
      .din_s       (din_s),
      .reg_rdata_i (reg_rdata_i),
      .status_i    (status_i),
      .reg_addr_o  (reg_addr_o),
      .reg_wdata_o (reg_wdata_o),
      .reg_we_o    (reg_we_o),
      .reg_re_o    (reg_re_o),
      .rd_hold_o   (rd_hold)
   );

   mcubus_waitgen #(
      .HOLD_CYC (HOLD_CYC)
   ) u_waitgen (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_vld_i   (acc_vld),
      .core_busy_i (core_busy_i),
      .wait_n_o    (wait_n_o)
   );

   // bus driver follows the raw pins so it releases without synchroniser delay
   assign mode_raw = eff_mode(BUS_MODE, mode_i);
   assign db_oe_o  = ~cs_n_i & rd_level(mode_raw, strb_a_i, strb_b_i);
   assign db_o     = rd_hold;

   // R4/R5: returned byte is stable while the host keeps reading
   p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (db_oe_o && $past(db_oe_o) && !acc_vld) |=> $stable(db_o));

endmodule

// File: tb/mcubus_host_if_tb.sv
module mcubus_host_if_tb;

   typedef struct {
      bit         is_wr;
      logic [7:0] addr;
      logic [7:0] data;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_i = 1'b0;
   logic       cs_n_i = 1'b1;
   logic       rs_i = 1'b0;
   logic       strb_a_i = 1'b1;
   logic       strb_b_i = 1'b1;
   logic [7:0] db_i = 8'h00;
   logic [7:0] db_o;
   logic       db_oe_o;
   logic       wait_n_o;
   logic       core_busy_i = 1'b0;
   logic [7:0] reg_addr_o;
   logic [7:0] reg_wdata_o;
   logic       reg_we_o;
   logic       reg_re_o;
   logic [7:0] reg_rdata_i;
   logic [7:0] status_i = 8'h00;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done = 0;
   exp_t sb_q[$];
   logic [7:0] cur_addr = 8'h00;

   always #5 clk = ~clk;

   // register file model: read data is a fixed function of the address
   assign reg_rdata_i = reg_addr_o ^ 8'h5A;

   mcubus_host_if u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode_i),
      .cs_n_i      (cs_n_i),
      .rs_i        (rs_i),
      .strb_a_i    (strb_a_i),
      .strb_b_i    (strb_b_i),
      .db_i        (db_i),
      .db_o        (db_o),
      .db_oe_o     (db_oe_o),
      .wait_n_o    (wait_n_o),
      .core_busy_i (core_busy_i),
      .reg_addr_o  (reg_addr_o),
      .reg_wdata_o (reg_wdata_o),
      .reg_we_o    (reg_we_o),
      .reg_re_o    (reg_re_o),
      .reg_rdata_i (reg_rdata_i),
      .status_i    (status_i)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every pulse, checks wait follows each pulse
   bit prev_pulse = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (prev_pulse) check("R9 wait after access", {7'd0, wait_n_o}, 8'd0);
         if (reg_we_o && reg_re_o) check("R7 pulse overlap", 8'd1, 8'd0);
         if (reg_we_o || reg_re_o) begin
            if (sb_q.size() == 0) begin
               check("R7 unexpected pulse", {7'd0, reg_we_o}, {7'd0, reg_re_o});
               n_bad += (reg_we_o == reg_re_o) ? 1 : 0;
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check(e.is_wr ? "R1/R2 pulse kind" : "R4 pulse kind", {7'd0, reg_we_o}, {7'd0, e.is_wr});
               check("R1/R4 pulse address", reg_addr_o, e.addr);
               if (e.is_wr) check("R1/R2 write data", reg_wdata_o, e.data);
            end
         end
         prev_pulse = reg_we_o | reg_re_o;
      end
   end

   task automatic idle_levels();
      strb_a_i = mode_i ? 1'b0 : 1'b1;
      strb_b_i = 1'b1;
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (wait_n_o) break;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic host_wr(input bit rs, input logic [7:0] d);
      if (!rs) sb_q.push_back('{is_wr: 1'b1, addr: cur_addr, data: d});
      else cur_addr = d;
      @(negedge clk);
      cs_n_i = 1'b0; rs_i = rs; db_i = d;
      if (mode_i) strb_b_i = 1'b0;
      repeat (2) @(negedge clk);
      if (mode_i) strb_a_i = 1'b1; else strb_b_i = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 no drive on write", {7'd0, db_oe_o}, 8'd0);
      repeat (2) @(negedge clk);
      if (mode_i) strb_a_i = 1'b0; else strb_b_i = 1'b1;
      repeat (4) @(negedge clk);
      cs_n_i = 1'b1;
      idle_levels();
      wait_ready();
   endtask

   task automatic host_rd(input bit rs, input logic [7:0] exp, input string req);
      if (!rs) sb_q.push_back('{is_wr: 1'b0, addr: cur_addr, data: 8'h00});
      @(negedge clk);
      cs_n_i = 1'b0; rs_i = rs;
      if (mode_i) strb_b_i = 1'b1;
      repeat (2) @(negedge clk);
      if (mode_i) strb_a_i = 1'b1; else strb_a_i = 1'b0;
      @(negedge clk);
      check("R8 drive during read", {7'd0, db_oe_o}, 8'd1);
      repeat (5) @(negedge clk);
      check(req, db_o, exp);
      if (mode_i) strb_a_i = 1'b0; else strb_a_i = 1'b1;
      @(negedge clk);
      check("R8 release after read", {7'd0, db_oe_o}, 8'd0);
      cs_n_i = 1'b1;
      idle_levels();
      wait_ready();
   endtask

   task automatic set_mode(input logic m);
      @(negedge clk);
      mode_i = m;
      idle_levels();
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 address after reset", reg_addr_o, 8'h00);
      check("R10 oe after reset", {7'd0, db_oe_o}, 8'd0);
      check("R10 wait after reset", {7'd0, wait_n_o}, 8'd1);
      check("R10 no pulse after reset", {6'd0, reg_we_o, reg_re_o}, 8'd0);

      // strobe/strobe mode
      set_mode(1'b0);
      host_wr(1'b1, 8'h12);                        // R3 command write
      check("R3 address latched", reg_addr_o, 8'h12);
      host_wr(1'b0, 8'hA5);                        // R1
      host_wr(1'b0, 8'h3C);                        // R1
      host_rd(1'b0, 8'h12 ^ 8'h5A, "R4 data read 8080");
      status_i = 8'hC3;
      host_rd(1'b1, 8'hC3, "R5 status read 8080");

      // R6: strobes with chip select high
      @(negedge clk);
      rs_i = 1'b1; db_i = 8'hEE;
      for (int k = 0; k < 3; k++) begin
         strb_b_i = 1'b0; repeat (4) @(negedge clk);
         strb_b_i = 1'b1; repeat (4) @(negedge clk);
         strb_a_i = 1'b0; repeat (4) @(negedge clk);
         check("R8 no drive while deselected", {7'd0, db_oe_o}, 8'd0);
         strb_a_i = 1'b1; repeat (4) @(negedge clk);
      end
      check("R6 address unchanged", reg_addr_o, 8'h12);
      check("R6 no queued pulse consumed", 8'(sb_q.size()), 8'd0);

      // enable/direction mode
      set_mode(1'b1);
      host_wr(1'b1, 8'h80);                        // R3
      check("R3 address latched 6800", reg_addr_o, 8'h80);
      host_wr(1'b0, 8'h01);                        // R2
      host_wr(1'b0, 8'hFF);                        // R2
      host_rd(1'b0, 8'h80 ^ 8'h5A, "R4 data read 6800");
      status_i = 8'h5E;
      host_rd(1'b1, 8'h5E, "R5 status read 6800");
      host_wr(1'b1, 8'h00);
      host_rd(1'b0, 8'h5A, "R4 data read at address 0");

      // R6 in enable/direction mode
      @(negedge clk);
      rs_i = 1'b1; strb_b_i = 1'b0;
      strb_a_i = 1'b1; repeat (4) @(negedge clk);
      strb_a_i = 1'b0; repeat (6) @(negedge clk);
      check("R6 address unchanged 6800", reg_addr_o, 8'h00);
      idle_levels();
      repeat (2) @(negedge clk);

      // R9 busy handling
      core_busy_i = 1'b1;
      repeat (2) @(negedge clk);
      check("R9 wait while busy", {7'd0, wait_n_o}, 8'd0);
      core_busy_i = 1'b0;
      repeat (2) @(negedge clk);
      check("R9 wait released", {7'd0, wait_n_o}, 8'd1);

      // R7 every expected pulse seen, no extras
      repeat (5) @(negedge clk);
      check("R7 scoreboard drained", 8'(sb_q.size()), 8'd0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule